// File: doc/BRIEF.md
# Free-Running 40-bit Timestamp Counter

This block keeps a 40-bit timestamp that counts up by one on every clock cycle in which an external tick enable is high, provided software has switched counting on. It has no interrupt output. Software reads it through a small register bus with two 32-bit words. The low word (offset 0x60) returns count bits [31:0]. The high word (offset 0x64) returns count bits [39:32] in bits [7:0] and the counting enable in bit 8. Writing the high word sets or clears the enable and leaves the count alone.

A single-byte snapshot keeps a split 40-bit read consistent. A small read-coherence state machine tracks it. In state `SNAP_LIVE` a high-word read returns the live upper byte. A low-word read captures the upper byte and takes the transition `LIVE_TO_HELD` into `SNAP_HELD`. In `SNAP_HELD` the next high-word read returns the captured byte and takes `HELD_TO_LIVE` back. Another low-word read while held re-captures the byte and stays in `SNAP_HELD` (`HELD_RECAPTURE`). All other bus activity keeps the current state (`LIVE_STAY`, `HELD_STAY`).

Read data is registered. It appears on `rdata` in the cycle after `rd_en` is sampled and holds until the next read.

Top module: `ts40_timestamp`

## Requirements
- R1: After reset the count is zero, counting is disabled, `rdata` is zero and the coherence state is `SNAP_LIVE`.
- R2: While enabled, the count increases by exactly one at each clock edge where `tick_en` is high. It does not change where `tick_en` is low.
- R3: While disabled, the count holds its value whatever `tick_en` does. Enabling again resumes from that value.
- R4: A write to offset 0x64 loads the enable from `wdata` bit 8 and ignores every other `wdata` bit. Writes to any other offset change neither the enable nor the count.
- R5: A read of offset 0x60 returns, one cycle later, count bits [LO_W-1:0] as they stood before that edge's increment, zero-extended to the bus width.
- R6: A read of offset 0x60 captures count bits [CNT_W-1:LO_W] at the same edge and leaves the state machine in `SNAP_HELD`. This holds also when it was already held.
- R7: A read of offset 0x64 in `SNAP_HELD` returns the captured upper bits in bits [HI_W-1:0] and the enable in bit 8, then returns to `SNAP_LIVE`.
- R8: A read of offset 0x64 in `SNAP_LIVE` returns the current upper count bits in bits [HI_W-1:0] and the enable in bit 8.
- R9: High-word bits above bit 8 read as zero. A read of any offset other than 0x60 and 0x64 returns all zeros.
- R10: The count wraps from all ones to zero on the next enabled tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick qualifier, one increment per high cycle |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (8) | Register byte offset |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |

## Verification
Several properties are checked on every cycle: single-step increments, holding while disabled or untimed, enable updates that follow only high-word writes, capture of the upper bits and entry to `SNAP_HELD` on a low read, release on a high read, and zero fill of unused read bits. Other behaviour only shows up in the bench's scenarios. These include the values a coherent low-then-high read sequence returns across a carry into the upper field, a re-capture while already held, resuming after a freeze, and the wrap from all ones to zero. The wrap is seen on a second, narrow instance, because a full 40-bit wrap cannot be reached in a run.

// File: rtl/ts40_pkg.sv
package ts40_pkg;

    // Read-coherence state of the upper count field
    typedef enum logic [0:0] {
        SNAP_LIVE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;

    // Kind of bus access decoded in one cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOW   = 2'd1,
        ACC_HIGH  = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/ts40_decode.sv
module ts40_decode
    import ts40_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter int          EN_BIT  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h60,
    parameter logic [7:0]  HI_ADDR = 8'h64
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output acc_kind_e         rd_kind,
    output logic              en_wr,
    output logic              en_val
);

    localparam logic [ADDR_W-1:0] LO_A    = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A    = ADDR_W'(HI_ADDR);
    localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;

    always_comb begin
        if (!rd_en) begin
            rd_kind = ACC_NONE;
        end else if (addr == LO_A) begin
            rd_kind = ACC_LOW;
        end else if (addr == HI_A) begin
            rd_kind = ACC_HIGH;
        end else begin
            rd_kind = ACC_OTHER;
        end
    end

    // Only the enable position of the write data carries meaning
    assign en_wr  = wr_en && (addr == HI_A);
    assign en_val = |(wdata & EN_MASK);

endmodule

// File: rtl/ts40_count_core.sv
module ts40_count_core #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             en_wr,
    input  logic             en_val,
    output logic [CNT_W-1:0] cnt,
    output logic             en
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (en_q && tick_en) begin
                cnt_q <= cnt_q + STEP;
            end
            if (en_wr) begin
                en_q <= en_val;
            end
        end
    end

    assign cnt = cnt_q;
    assign en  = en_q;

endmodule

// File: rtl/ts40_snap_fsm.sv
module ts40_snap_fsm
    import ts40_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_kind_e       rd_kind,
    input  logic [HI_W-1:0] hi_live,
    output snap_state_e     state,
    output logic [HI_W-1:0] snap,
    output logic [HI_W-1:0] hi_view
);

    snap_state_e     state_q;
    snap_state_e     state_d;
    logic [HI_W-1:0] snap_q;

    // State register and captured upper field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SNAP_LIVE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_kind == ACC_LOW) begin
                snap_q <= hi_live;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_LIVE: begin
                if (rd_kind == ACC_LOW) begin
                    state_d = SNAP_HELD;   // LIVE_TO_HELD
                end
            end
            SNAP_HELD: begin
                if (rd_kind == ACC_HIGH) begin
                    state_d = SNAP_LIVE;   // HELD_TO_LIVE
                end
            end
        endcase
    end

    // Outputs: which upper field a high read presents
    always_comb begin
        unique case (state_q)
            SNAP_LIVE: hi_view = hi_live;
            SNAP_HELD: hi_view = snap_q;
        endcase
    end

    assign state = state_q;
    assign snap  = snap_q;

endmodule

// File: rtl/ts40_rdmux.sv
module ts40_rdmux
    import ts40_pkg::*;
#(
    parameter int LO_W   = 32,
    parameter int HI_W   = 8,
    parameter int DATA_W = 32,
    parameter int EN_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         rd_kind,
    input  logic [LO_W-1:0]   lo_live,
    input  logic [HI_W-1:0]   hi_view,
    input  logic              en,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] lo_word;
    logic [DATA_W-1:0] hi_word;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        lo_word             = '0;
        lo_word[LO_W-1:0]   = lo_live;
        hi_word             = '0;
        hi_word[HI_W-1:0]   = hi_view;
        hi_word[EN_BIT]     = en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (rd_kind)
                ACC_NONE:  rdata_q <= rdata_q;
                ACC_LOW:   rdata_q <= lo_word;
                ACC_HIGH:  rdata_q <= hi_word;
                ACC_OTHER: rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ts40_timestamp.sv
module ts40_timestamp
    import ts40_pkg::*;
#(
    parameter int          CNT_W   = 40,
    parameter int          LO_W    = 32,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter int          EN_BIT  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h60,
    parameter logic [7:0]  HI_ADDR = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int HI_W = CNT_W - LO_W;

    acc_kind_e        rd_kind;
    logic             en_wr;
    logic             en_val;
    logic [CNT_W-1:0] cnt_w;
    logic             en_w;
    snap_state_e      state_w;
    logic [HI_W-1:0]  snap_w;
    logic [HI_W-1:0]  hi_view;

    ts40_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EN_BIT (EN_BIT),
        .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR)
    ) u_decode (
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rd_kind(rd_kind),
        .en_wr  (en_wr),
        .en_val (en_val)
    );

    ts40_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .en_wr  (en_wr),
        .en_val (en_val),
        .cnt    (cnt_w),
        .en     (en_w)
    );

    ts40_snap_fsm #(
        .HI_W(HI_W)
    ) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_kind(rd_kind),
        .hi_live(cnt_w[CNT_W-1:LO_W]),
        .state  (state_w),
        .snap   (snap_w),
        .hi_view(hi_view)
    );

    ts40_rdmux #(
        .LO_W  (LO_W),
        .HI_W  (HI_W),
        .DATA_W(DATA_W),
        .EN_BIT(EN_BIT)
    ) u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_kind(rd_kind),
        .lo_live(cnt_w[LO_W-1:0]),
        .hi_view(hi_view),
        .en     (en_w),
        .rdata  (rdata)
    );

endmodule

// File: rtl/ts40_timestamp_chk.sv
module ts40_timestamp_chk
    import ts40_pkg::*;
#(
    parameter int          CNT_W   = 40,
    parameter int          LO_W    = 32,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter int          EN_BIT  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h60,
    parameter logic [7:0]  HI_ADDR = 8'h64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    rd_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [DATA_W-1:0]       rdata,
    input  logic [CNT_W-1:0]        cnt,
    input  logic                    en,
    input  snap_state_e             state,
    input  logic [CNT_W-LO_W-1:0]   snap
);

    localparam logic [ADDR_W-1:0] LO_A    = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A    = ADDR_W'(HI_ADDR);
    localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;

    logic rd_lo, rd_hi, rd_oth, wr_hi, wbit;
    assign rd_lo  = rd_en && (addr == LO_A);
    assign rd_hi  = rd_en && (addr == HI_A);
    assign rd_oth = rd_en && (addr != LO_A) && (addr != HI_A);
    assign wr_hi  = wr_en && (addr == HI_A);
    assign wbit   = |(wdata & EN_MASK);

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick_en) |=> (cnt == $past(cnt) + 1'b1));

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));

    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

    a_r4_enable_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (en == $past(wbit)));

    a_r4_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(en));

    a_r5_low_word: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (rdata[LO_W-1:0] == $past(cnt[LO_W-1:0])));

    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (state == SNAP_HELD) && (snap == $past(cnt[CNT_W-1:LO_W])));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && state == SNAP_HELD) |=> (state == SNAP_LIVE));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (rdata[DATA_W-1:EN_BIT+1] == '0));

    a_r9_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oth |=> (rdata == '0));

endmodule

bind ts40_timestamp ts40_timestamp_chk #(
    .CNT_W  (CNT_W),
    .LO_W   (LO_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .EN_BIT (EN_BIT),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .cnt    (cnt_w),
    .en     (en_w),
    .state  (state_w),
    .snap   (snap_w)
);

// File: tb/ts40_timestamp_bench.sv
module ts40_timestamp_bench;

    localparam logic [7:0] LO = 8'h60;
    localparam logic [7:0] HI = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        rd;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata_m;
    logic [31:0] rdata_s;

    always #5 clk = ~clk;

    // Full-width instance
    ts40_timestamp u_ts40_timestamp (
        .clk(clk), .rst_n(rst_n), .tick_en(tick), .rd_en(rd), .wr_en(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata_m)
    );

    // Narrow instance, same bus, so the wrap (R10) and the upper-field carry are reachable
    ts40_timestamp #(.CNT_W(12), .LO_W(8)) u_ts40_timestamp_small (
        .clk(clk), .rst_n(rst_n), .tick_en(tick), .rd_en(rd), .wr_en(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata_s)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state built from the requirements
    logic [39:0] m_cnt;
    logic        m_en;
    logic        m_held;
    logic [7:0]  m_snap;
    logic [3:0]  s_snap;
    logic        pend;
    string       cur_tag;
    logic [31:0] exp_m[$];
    logic [31:0] exp_s[$];
    string       tag_q[$];

    function automatic void check(string tag, string who, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual %h expected %h", tag, who, act, exp);
        end
    endfunction

    // Driver side: expected items pushed when a read is sampled
    always @(posedge clk) begin
        logic [31:0] e_m;
        logic [31:0] e_s;
        if (!rst_n) begin
            m_cnt  = '0;
            m_en   = 1'b0;
            m_held = 1'b0;
            m_snap = '0;
            s_snap = '0;
            pend  <= 1'b0;
        end else begin
            pend <= rd;
            if (rd) begin
                e_m = '0;
                e_s = '0;
                if (addr == LO) begin
                    e_m       = m_cnt[31:0];
                    e_s[7:0]  = m_cnt[7:0];
                    m_snap    = m_cnt[39:32];
                    s_snap    = m_cnt[11:8];
                    m_held    = 1'b1;
                end else if (addr == HI) begin
                    e_m[7:0]  = m_held ? m_snap : m_cnt[39:32];
                    e_s[3:0]  = m_held ? s_snap : m_cnt[11:8];
                    e_m[8]    = m_en;
                    e_s[8]    = m_en;
                    m_held    = 1'b0;
                end
                exp_m.push_back(e_m);
                exp_s.push_back(e_s);
                tag_q.push_back(cur_tag);
            end
            if (m_en && tick) m_cnt = m_cnt + 40'd1;
            if (wr && addr == HI) m_en = wdata[8];
        end
    end

    // Monitor: compare read data in the cycle after the read
    always @(negedge clk) begin
        if (rst_n === 1'b1 && pend === 1'b1) begin
            if (exp_m.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R5: actual read data without request expected none");
            end else begin
                string t;
                t = tag_q.pop_front();
                check(t, "wide", rdata_m, exp_m.pop_front());
                check(t, "narrow", rdata_s, exp_s.pop_front());
            end
        end
    end

    task automatic step(input bit r, input bit w, input logic [7:0] a,
                        input logic [31:0] d, input bit tk, input string t);
        @(negedge clk);
        rd      = r;
        wr      = w;
        addr    = a;
        wdata   = d;
        tick    = tk;
        cur_tag = t;
    endtask

    task automatic rd_reg(input logic [7:0] a, input bit tk, input string t);
        step(1'b1, 1'b0, a, 32'h0, tk, t);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        step(1'b0, 1'b1, a, d, 1'b0, "");
    endtask

    task automatic ticks(input int n, input int every);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, 8'h00, 32'h0, (i % every) == 0, "");
        end
    endtask

    task automatic advance_to(input logic [11:0] tgt);
        forever begin
            @(negedge clk);
            rd = 1'b0;
            wr = 1'b0;
            if (m_cnt[11:0] == tgt) begin
                tick = 1'b0;
                break;
            end
            tick = 1'b1;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rd = 1'b0; wr = 1'b0; tick = 1'b0;
        addr = '0; wdata = '0; cur_tag = "";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "wide", rdata_m, 32'h0);
        check("R1", "narrow", rdata_s, 32'h0);
        rd_reg(LO, 1'b0, "R1");
        rd_reg(HI, 1'b0, "R1");

        // Disabled: ticks must not count
        ticks(10, 1);
        rd_reg(LO, 1'b0, "R3");

        // Write with bit 8 clear and all else set; then enable bit at a wrong offset
        wr_reg(HI, 32'hFFFF_FEFF);
        ticks(5, 1);
        rd_reg(HI, 1'b0, "R4");
        wr_reg(8'h68, 32'h0000_0100);
        ticks(5, 1);
        rd_reg(HI, 1'b0, "R4");
        rd_reg(LO, 1'b0, "R4");

        // Enable and count
        wr_reg(HI, 32'h0000_0100);
        ticks(20, 1);
        rd_reg(LO, 1'b0, "R2");
        rd_reg(HI, 1'b0, "R2");
        ticks(30, 3);
        rd_reg(LO, 1'b0, "R2");
        rd_reg(LO, 1'b1, "R5");
        rd_reg(LO, 1'b1, "R5");

        // Freeze and resume
        wr_reg(HI, 32'h0);
        ticks(12, 1);
        rd_reg(LO, 1'b1, "R3");
        rd_reg(HI, 1'b1, "R3");
        wr_reg(HI, 32'h0000_0100);
        ticks(7, 2);
        rd_reg(LO, 1'b0, "R3");

        // Unmapped offset and upper zero bits
        rd_reg(8'h68, 1'b0, "R9");
        rd_reg(HI, 1'b0, "R9");

        // Coherent read across a carry into the upper field
        advance_to(12'h2FE);
        rd_reg(LO, 1'b1, "R6");
        ticks(3, 1);
        rd_reg(HI, 1'b0, "R7");
        rd_reg(HI, 1'b0, "R8");
        advance_to(12'h3FF);
        rd_reg(LO, 1'b1, "R6");
        ticks(2, 1);
        rd_reg(LO, 1'b0, "R6");
        rd_reg(HI, 1'b0, "R7");
        ticks(4, 1);
        rd_reg(HI, 1'b1, "R8");

        // Wrap of the narrow count
        advance_to(12'hFFF);
        rd_reg(LO, 1'b0, "R10");
        rd_reg(HI, 1'b0, "R10");
        ticks(1, 1);
        rd_reg(LO, 1'b0, "R10");
        rd_reg(HI, 1'b0, "R10");

        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, "");
        step(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, "");
        if (exp_m.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5: actual %0d reads unanswered expected 0", exp_m.size());
        end
        finish_run();
    end

endmodule